// File: doc/BRIEF.md
# AXI4-Lite Register Handshake Bridge

This block is an AXI4-Lite slave front end. It turns the five channel handshakes of the bus into a small register protocol for user logic. When the host writes, the bridge waits until it holds both the write address and the write data. It then raises a one-cycle write request and keeps the byte address and 32-bit data steady until the user logic pulses an acknowledge. When the host reads, the bridge raises a one-cycle read request with the address. It then waits for the user logic to place a word on its data bus and pulse a ready strobe.

The user logic decodes the byte address against word offsets (register n sits at byte address n shifted left by 2). It can pulse a bad-address flag alongside its acknowledge or ready strobe, and the bridge turns that flag into an error response. The bridge handles one transaction at a time. All flops use an asynchronous active-low reset that is released through a two-stage synchronizer.

Top module: `axil_reg_bridge`

## Requirements
- R1: Two clock edges after reset is released, the following hold. AWREADY, WREADY and ARREADY are high. BVALID, RVALID, the write request and the read request are low. The read data output is zero.
- R2: The write request is a pulse that lasts exactly one cycle. It is raised only after both the write address and the write data have been accepted. It carries the AXI byte address unchanged, including its two low bits, together with the write data.
- R3: From the write request up to the acknowledge cycle, the address and write data seen by the user logic do not change.
- R4: After a write acknowledge, BVALID rises on the next cycle. BRESP is 2'b00 (OKAY), or 2'b10 (SLVERR) when the bad-address flag came with the acknowledge. BVALID and BRESP hold until BREADY is seen.
- R5: After a read address is accepted, a read request pulse that lasts exactly one cycle is raised with the byte address unchanged.
- R6: After a read-ready strobe, RVALID rises on the next cycle. RDATA carries the word the user logic supplied, and RRESP is 2'b00. RVALID, RDATA and RRESP hold until RREADY is seen.
- R7: A read-ready strobe that comes with the bad-address flag gives RRESP 2'b10 and RDATA 0x00000000, whatever word the user logic supplied.
- R8: While a transaction is in flight, AWREADY, WREADY and ARREADY stay low. A transaction is in flight from its request until its response is accepted.
- R9: When a complete write and a read address are both pending, the write request is issued first. The read request follows after the write response has been accepted.
- R10: A write acknowledge or read-ready strobe that does not answer an outstanding request of its own kind is ignored. No response is raised because of it.
- R11: After BREADY or RREADY is accepted, the matching valid drops on the next cycle and the bridge accepts a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AXI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| usr_addr | output | ADDR_W | Byte address toward user logic |
| usr_wr_data | output | DATA_W | Write data toward user logic |
| usr_wr_req | output | 1 | One-cycle write request |
| usr_wr_ack | input | 1 | One-cycle write acknowledge |
| usr_rd_req | output | 1 | One-cycle read request |
| usr_rd_data | input | DATA_W | Read data from user logic |
| usr_rd_rdy | input | 1 | One-cycle read data ready |
| usr_bad_addr | input | 1 | Unknown-address flag, sampled with ack or ready |

## Verification
The bench sends the write address several cycles before the write data. A bridge that starts too early would issue a request carrying stale data. It also presents a complete write and a read in the same cycle, which catches a read that overtakes the write or a pair of requests raised together. The bench holds back BREADY and RREADY, sends unaligned addresses with the bad flag, and makes the user logic supply a nonzero word along with that flag. These cases expose a response that drops early, a lost SLVERR, or leaked read data. Stray acknowledge and ready strobes, some of them sent while the other kind of transaction is waiting, must not produce a response.

// File: rtl/axil_reg_bridge_pkg.sv
package axil_reg_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_WAIT = 3'd1,
    ST_WR_RESP = 3'd2,
    ST_RD_WAIT = 3'd3,
    ST_RD_RESP = 3'd4
  } brg_state_t;

  localparam int RESP_W = 2;
  localparam logic [RESP_W-1:0] RESP_OKAY   = 2'b00;
  localparam logic [RESP_W-1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/axil_rst_sync.sv
module axil_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/axil_chan_hold.sv
module axil_chan_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic         vld,
  input  logic [W-1:0] din,
  input  logic         drop,
  output logic         rdy,
  output logic         held,
  output logic [W-1:0] q
);
  logic         take;
  logic         held_d;
  logic [W-1:0] q_d;

  assign rdy  = open && !held;
  assign take = vld && rdy;

  always_comb begin
    held_d = held;
    q_d    = q;
    if (take) begin
      held_d = 1'b1;
      q_d    = din;
    end else if (drop) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      q    <= '0;
    end else begin
      held <= held_d;
      if (take) q <= q_d;
    end
  end
endmodule

// File: rtl/axil_reg_seq.sv
module axil_reg_seq
  import axil_reg_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_held,
  input  logic              w_held,
  input  logic              ar_held,
  input  logic              wr_ack,
  input  logic              rd_rdy,
  input  logic              bad_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              bready,
  input  logic              rready,
  output logic              idle,
  output logic              wsel,
  output logic              wr_req,
  output logic              rd_req,
  output logic              drop_wr,
  output logic              drop_rd,
  output logic              wr_waiting,
  output logic              rd_waiting,
  output logic              bvalid,
  output logic [RESP_W-1:0] bresp,
  output logic              rvalid,
  output logic [RESP_W-1:0] rresp,
  output logic [DATA_W-1:0] rdata
);
  brg_state_t        state_q, state_d;
  logic              wr_req_d, rd_req_d;
  logic              wsel_d;
  logic              wsel_en;
  logic [RESP_W-1:0] resp_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    state_d  = state_q;
    wr_req_d = 1'b0;
    rd_req_d = 1'b0;
    drop_wr  = 1'b0;
    drop_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (aw_held && w_held) begin
          state_d  = ST_WR_WAIT;
          wr_req_d = 1'b1;
        end else if (ar_held) begin
          state_d  = ST_RD_WAIT;
          rd_req_d = 1'b1;
        end
      end
      ST_WR_WAIT: begin
        if (wr_ack) begin
          state_d = ST_WR_RESP;
          drop_wr = 1'b1;
        end
      end
      ST_WR_RESP: if (bready) state_d = ST_IDLE;
      ST_RD_WAIT: begin
        if (rd_rdy) begin
          state_d = ST_RD_RESP;
          drop_rd = 1'b1;
        end
      end
      ST_RD_RESP: if (rready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign wsel_en = wr_req_d || rd_req_d;
  assign wsel_d  = wr_req_d;
  assign resp_d  = bad_addr ? RESP_SLVERR : RESP_OKAY;
  assign rdata_d = bad_addr ? '0 : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      wsel    <= 1'b0;
      bresp   <= RESP_OKAY;
      rresp   <= RESP_OKAY;
      rdata   <= '0;
    end else begin
      state_q <= state_d;
      wr_req  <= wr_req_d;
      rd_req  <= rd_req_d;
      if (wsel_en) wsel  <= wsel_d;
      if (drop_wr) bresp <= resp_d;
      if (drop_rd) begin
        rresp <= resp_d;
        rdata <= rdata_d;
      end
    end
  end

  assign idle       = (state_q == ST_IDLE);
  assign wr_waiting = (state_q == ST_WR_WAIT);
  assign rd_waiting = (state_q == ST_RD_WAIT);
  assign bvalid     = (state_q == ST_WR_RESP);
  assign rvalid     = (state_q == ST_RD_RESP);
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axil_reg_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ADDR_W-1:0] usr_addr,
  output logic [DATA_W-1:0] usr_wr_data,
  output logic              usr_wr_req,
  input  logic              usr_wr_ack,
  output logic              usr_rd_req,
  input  logic [DATA_W-1:0] usr_rd_data,
  input  logic              usr_rd_rdy,
  input  logic              usr_bad_addr
);
  logic              rst_core_n;
  logic              idle;
  logic              wsel;
  logic              drop_wr, drop_rd;
  logic              aw_held, w_held, ar_held;
  logic [ADDR_W-1:0] aw_q, ar_q;
  logic              wr_waiting, rd_waiting;

  axil_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  axil_chan_hold #(.W(ADDR_W)) u_aw (
    .clk (clk), .rst_n (rst_core_n), .open (idle),
    .vld (s_awvalid), .din (s_awaddr), .drop (drop_wr),
    .rdy (s_awready), .held (aw_held), .q (aw_q)
  );

  axil_chan_hold #(.W(DATA_W)) u_w (
    .clk (clk), .rst_n (rst_core_n), .open (idle),
    .vld (s_wvalid), .din (s_wdata), .drop (drop_wr),
    .rdy (s_wready), .held (w_held), .q (usr_wr_data)
  );

  axil_chan_hold #(.W(ADDR_W)) u_ar (
    .clk (clk), .rst_n (rst_core_n), .open (idle),
    .vld (s_arvalid), .din (s_araddr), .drop (drop_rd),
    .rdy (s_arready), .held (ar_held), .q (ar_q)
  );

  axil_reg_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .aw_held    (aw_held),
    .w_held     (w_held),
    .ar_held    (ar_held),
    .wr_ack     (usr_wr_ack),
    .rd_rdy     (usr_rd_rdy),
    .bad_addr   (usr_bad_addr),
    .rd_data    (usr_rd_data),
    .bready     (s_bready),
    .rready     (s_rready),
    .idle       (idle),
    .wsel       (wsel),
    .wr_req     (usr_wr_req),
    .rd_req     (usr_rd_req),
    .drop_wr    (drop_wr),
    .drop_rd    (drop_rd),
    .wr_waiting (wr_waiting),
    .rd_waiting (rd_waiting),
    .bvalid     (s_bvalid),
    .bresp      (s_bresp),
    .rvalid     (s_rvalid),
    .rresp      (s_rresp),
    .rdata      (s_rdata)
  );

  assign usr_addr = wsel ? aw_q : ar_q;
endmodule

// File: rtl/axil_reg_bridge_chk.sv
module axil_reg_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awready,
  input logic              s_wready,
  input logic              s_arready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [ADDR_W-1:0] usr_addr,
  input logic [DATA_W-1:0] usr_wr_data,
  input logic              usr_wr_req,
  input logic              usr_wr_ack,
  input logic              usr_rd_req,
  input logic              wr_waiting,
  input logic              rd_waiting
);
  AST_WR_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wr_req |=> !usr_wr_req); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_waiting && !usr_wr_ack) |=> ($stable(usr_addr) && $stable(usr_wr_data))); // R3
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R4
  AST_RD_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rd_req |=> !usr_rd_req); // R5
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp))); // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rresp == 2'b10) |-> (s_rdata == '0)); // R7
  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid || s_rvalid || wr_waiting || rd_waiting) |-> !(s_awready || s_wready || s_arready)); // R8
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(usr_wr_req && usr_rd_req)); // R9
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_waiting && usr_wr_ack && !s_bvalid) |=> !s_bvalid); // R10
  AST_B_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && s_bready) |=> !s_bvalid); // R11
endmodule

bind axil_reg_bridge axil_reg_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_awready   (s_awready),
  .s_wready    (s_wready),
  .s_arready   (s_arready),
  .s_bresp     (s_bresp),
  .s_bvalid    (s_bvalid),
  .s_bready    (s_bready),
  .s_rdata     (s_rdata),
  .s_rresp     (s_rresp),
  .s_rvalid    (s_rvalid),
  .s_rready    (s_rready),
  .usr_addr    (usr_addr),
  .usr_wr_data (usr_wr_data),
  .usr_wr_req  (usr_wr_req),
  .usr_wr_ack  (usr_wr_ack),
  .usr_rd_req  (usr_rd_req),
  .wr_waiting  (wr_waiting),
  .rd_waiting  (rd_waiting)
);

// File: tb/axil_reg_bridge_test.sv
module axil_reg_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NREG   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] s_awaddr = '0;
  logic              s_awvalid = 1'b0;
  logic              s_awready;
  logic [DATA_W-1:0] s_wdata = '0;
  logic              s_wvalid = 1'b0;
  logic              s_wready;
  logic [1:0]        s_bresp;
  logic              s_bvalid;
  logic              s_bready = 1'b0;
  logic [ADDR_W-1:0] s_araddr = '0;
  logic              s_arvalid = 1'b0;
  logic              s_arready;
  logic [DATA_W-1:0] s_rdata;
  logic [1:0]        s_rresp;
  logic              s_rvalid;
  logic              s_rready = 1'b0;
  logic [ADDR_W-1:0] usr_addr;
  logic [DATA_W-1:0] usr_wr_data;
  logic              usr_wr_req;
  logic              usr_wr_ack = 1'b0;
  logic              usr_rd_req;
  logic [DATA_W-1:0] usr_rd_data = '0;
  logic              usr_rd_rdy = 1'b0;
  logic              usr_bad_addr = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] mem [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  axil_reg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit addr_bad(input logic [ADDR_W-1:0] a);
    return (a[1:0] != 2'b00) || (int'(a[ADDR_W-1:2]) >= NREG);
  endfunction

  function automatic logic [1:0] resp_for(input bit bad);
    return bad ? 2'b10 : 2'b00;
  endfunction

  task automatic host_aw_w(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int w_delay);
    bit aw_done = 0, w_done = 0, aw_acc, w_acc;
    int cyc = 0;
    s_awaddr = a; s_awvalid = 1'b1;
    s_wdata = d;
    if (w_delay == 0) s_wvalid = 1'b1;
    while (!(aw_done && w_done)) begin
      aw_acc = s_awvalid && s_awready;
      w_acc  = s_wvalid && s_wready;
      @(negedge clk);
      cyc++;
      if (aw_acc) begin s_awvalid = 1'b0; aw_done = 1; end
      if (w_acc)  begin s_wvalid = 1'b0;  w_done = 1; end
      if (!w_done) begin
        chk(!usr_wr_req, "R2 no request before data", {31'd0, usr_wr_req}, 32'd0);
        if (cyc == w_delay) s_wvalid = 1'b1;
      end
    end
  endtask

  task automatic host_ar(input logic [ADDR_W-1:0] a);
    bit acc;
    s_araddr = a; s_arvalid = 1'b1;
    do begin
      acc = s_arready;
      @(negedge clk);
    end while (!acc);
    s_arvalid = 1'b0;
  endtask

  task automatic user_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int dly, input bit bad);
    int t = 0;
    while (!usr_wr_req && t < 20) begin @(negedge clk); t++; end
    chk(usr_wr_req, "R2 write request seen", {31'd0, usr_wr_req}, 32'd1);
    chk(usr_addr == a, "R2 write address", {24'd0, usr_addr}, {24'd0, a});
    chk(usr_wr_data == d, "R2 write data", usr_wr_data, d);
    chk(!s_awready && !s_wready && !s_arready, "R8 readies low while busy",
        {29'd0, s_awready, s_wready, s_arready}, 32'd0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(!usr_wr_req, "R2 request is one cycle", {31'd0, usr_wr_req}, 32'd0);
      chk(usr_addr == a && usr_wr_data == d, "R3 address and data held", usr_wr_data, d);
      chk(!s_bvalid, "R4 no response before ack", {31'd0, s_bvalid}, 32'd0);
    end
    usr_wr_ack = 1'b1; usr_bad_addr = bad;
    @(negedge clk);
    usr_wr_ack = 1'b0; usr_bad_addr = 1'b0;
    if (!bad) mem[a[4:2]] = d;
  endtask

  task automatic host_b(input logic [1:0] exp, input int hold, input bit chk_open);
    chk(s_bvalid, "R4 bvalid after ack", {31'd0, s_bvalid}, 32'd1);
    chk(s_bresp == exp, "R4 bresp", {30'd0, s_bresp}, {30'd0, exp});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(s_bvalid && s_bresp == exp, "R4 response held", {30'd0, s_bresp}, {30'd0, exp});
    end
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    chk(!s_bvalid, "R11 bvalid drops", {31'd0, s_bvalid}, 32'd0);
    if (chk_open) chk(s_awready, "R11 accepting again", {31'd0, s_awready}, 32'd1);
  endtask

  task automatic user_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int dly,
                         input bit bad, input bit stray);
    int t = 0;
    while (!usr_rd_req && t < 20) begin @(negedge clk); t++; end
    chk(usr_rd_req, "R5 read request seen", {31'd0, usr_rd_req}, 32'd1);
    chk(usr_addr == a, "R5 read address", {24'd0, usr_addr}, {24'd0, a});
    chk(!s_awready && !s_wready && !s_arready, "R8 readies low while busy",
        {29'd0, s_awready, s_wready, s_arready}, 32'd0);
    for (int i = 0; i < dly; i++) begin
      if (stray && i == 0) usr_wr_ack = 1'b1;
      @(negedge clk);
      usr_wr_ack = 1'b0;
      chk(!usr_rd_req, "R5 request is one cycle", {31'd0, usr_rd_req}, 32'd0);
      chk(!s_rvalid && !s_bvalid, "R10 no response before ready", {30'd0, s_rvalid, s_bvalid}, 32'd0);
    end
    usr_rd_data = d; usr_rd_rdy = 1'b1; usr_bad_addr = bad;
    @(negedge clk);
    usr_rd_rdy = 1'b0; usr_bad_addr = 1'b0; usr_rd_data = 32'h5A5A_A5A5;
  endtask

  task automatic host_r(input logic [DATA_W-1:0] exp_d, input logic [1:0] exp_r, input int hold, input string tag);
    chk(s_rvalid, "R6 rvalid after ready", {31'd0, s_rvalid}, 32'd1);
    chk(s_rdata == exp_d, tag, s_rdata, exp_d);
    chk(s_rresp == exp_r, tag, {30'd0, s_rresp}, {30'd0, exp_r});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(s_rvalid && s_rdata == exp_d && s_rresp == exp_r, "R6 read response held", s_rdata, exp_d);
    end
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    chk(!s_rvalid && s_arready, "R11 rvalid drops, accepting again", {30'd0, s_rvalid, s_arready}, 32'd1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(s_awready && s_wready && s_arready, "R1 readies after reset",
        {29'd0, s_awready, s_wready, s_arready}, 32'd7);
    chk(!s_bvalid && !s_rvalid && !usr_wr_req && !usr_rd_req, "R1 valids low after reset",
        {28'd0, s_bvalid, s_rvalid, usr_wr_req, usr_rd_req}, 32'd0);
    chk(s_rdata == '0, "R1 rdata cleared", s_rdata, 32'd0);

    // R10 stray strobes while idle
    usr_wr_ack = 1'b1; usr_rd_rdy = 1'b1; usr_rd_data = 32'hFFFF_FFFF;
    @(negedge clk);
    usr_wr_ack = 1'b0; usr_rd_rdy = 1'b0;
    @(negedge clk);
    chk(!s_bvalid && !s_rvalid && s_awready, "R10 stray strobes ignored",
        {29'd0, s_bvalid, s_rvalid, s_awready}, 32'd1);

    // directed write, data late (R2), slow ack (R3), held response (R4)
    host_aw_w(8'h04, 32'hC0FF_EE01, 3);
    user_wr(8'h04, 32'hC0FF_EE01, 3, 0);
    host_b(2'b00, 3, 1);

    // directed read back (R6) with stray write ack while waiting (R10)
    host_ar(8'h04);
    user_rd(8'h04, mem[1], 2, 0, 1);
    chk(!s_bvalid, "R10 stray ack during read", {31'd0, s_bvalid}, 32'd0);
    host_r(32'hC0FF_EE01, 2'b00, 2, "R6 read data");

    // bad write address -> SLVERR (R4), unaligned byte address kept (R2)
    host_aw_w(8'h0A, 32'h1234_5678, 0);
    user_wr(8'h0A, 32'h1234_5678, 0, 1);
    host_b(2'b10, 1, 1);

    // bad read with nonzero user data (R7)
    host_ar(8'h1C);
    user_rd(8'h1C, 32'hDEAD_BEEF, 1, 1, 0);
    host_r(32'h0, 2'b10, 1, "R7 error read zero");

    // simultaneous write and read (R9)
    fork
      host_aw_w(8'h08, 32'hAAAA_5555, 0);
      host_ar(8'h00);
    join
    chk(!usr_rd_req, "R9 read not first", {31'd0, usr_rd_req}, 32'd0);
    user_wr(8'h08, 32'hAAAA_5555, 1, 0);
    chk(!usr_rd_req, "R9 read waits for write response", {31'd0, usr_rd_req}, 32'd0);
    host_b(2'b00, 2, 0);
    user_rd(8'h00, mem[0], 0, 0, 0);
    host_r(mem[0], 2'b00, 0, "R9 read after write");

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      bit bad;
      a = {3'd0, 3'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0};
      bad = addr_bad(a);
      if ($urandom_range(0, 1) == 1) begin
        d = $urandom();
        host_aw_w(a, d, $urandom_range(0, 2));
        user_wr(a, d, $urandom_range(0, 3), bad);
        host_b(resp_for(bad), $urandom_range(0, 2), 1);
      end else begin
        d = bad ? (32'hBAD0_0000 | 32'(a)) : mem[a[4:2]];
        host_ar(a);
        user_rd(a, d, $urandom_range(0, 3), bad, 0);
        host_r(bad ? 32'h0 : d, resp_for(bad), $urandom_range(0, 2), bad ? "R7 random error read" : "R6 random read");
      end
    end

    summary();
    $finish;
  end
endmodule